// File: doc/BRIEF.md
# Three-Wire Tuning Word Receiver

This block is the receiving end of a write-only three-wire control port that sets a 32-step tunable capacitor bank. An external master raises an enable line, clocks eight data bits in with the most significant bit first, and then lowers enable. The receiver oversamples the three serial lines on its own system clock. It shifts a bit in on each rising edge of the serial clock while enable is high. When enable falls, it moves the shifted word into its output register.

No bit count is kept: the shift register always holds the last eight bits received. The five least significant bits of a latched word give the capacitor code. The next bit selects standby. The two top bits are reserved. A word with a reserved bit set is still applied, and a sticky error flag is also raised. A one-cycle strobe marks each word that takes effect. If enable falls without any serial clock edge since it rose, nothing is latched.

Top module: `tw_rx`

## Requirements
- R1: After reset the capacitor code is 00000, standby is 0, the strobe is 0 and the error flag is 0.
- R2: Bits are sampled on rising serial clock edges while enable is high, first bit most significant. The latched word's bits 4..0 drive `cap_code_o`.
- R3: No bit count is kept. When more than eight bits arrive in one enable window, the latched word is the last eight received.
- R4: Outputs change only on the falling edge of enable. While enable is high, the code and standby outputs keep their previous values.
- R5: Bit 5 of the latched word drives `standby_o`. A value of 1 selects low-current standby and 0 selects active.
- R6: A latched word with bit 7 or bit 6 set is still applied and sets `rsvd_err_o`. The flag stays set until reset.
- R7: If enable falls with no rising serial clock edge since it rose, the outputs are unchanged and no strobe is produced.
- R8: `update_o` is high for exactly one system clock per accepted word.
- R9: Rising serial clock edges while enable is low do not shift. After a short frame, the word is the earlier contents shifted by only the bits of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| sdat_i | input | 1 | Serial data from the master |
| sen_i | input | 1 | Enable line from the master, high during a transfer |
| cap_code_o | output | 5 | Active capacitor code |
| standby_o | output | 1 | Standby request |
| update_o | output | 1 | One-cycle pulse when a new word takes effect |
| rsvd_err_o | output | 1 | Sticky flag: a word with a reserved bit set was latched |

## Verification
The assertions assume the serial lines change slowly compared with the system clock. Each high or low phase of the serial clock and enable lines must last several system clocks, so that every edge is detected as a separate event. They also assume serial data is stable around each rising serial clock edge. The bench drives all three lines from the system clock's falling edge. It holds each phase for two to four system clocks and changes data only while the serial clock is low. It never moves enable and the serial clock in the same cycle.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int WORD_W  = 8;
  localparam int CODE_W  = 5;
  localparam int RSVD_W  = WORD_W - CODE_W - 1;
  localparam int LINES_N = 3;
  localparam int SCLK_IDX = 0;
  localparam int SDAT_IDX = 1;
  localparam int SEN_IDX  = 2;

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic              standby;
    logic [CODE_W-1:0] code;
  } tw_word_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
      prev_q <= '0;
    end else begin
      pipe_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              armed_o
);
  logic [WORD_W-1:0] sr_q;
  logic              armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
      // armed once at least one bit arrived in this enable window
      if (start_i)      armed_q <= 1'b0;
      else if (shift_i) armed_q <= 1'b1;
    end
  end

  assign word_o  = sr_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/tw_latch.sv
module tw_latch
  import tw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  tw_word_t          word_i,
  output logic [CODE_W-1:0] code_o,
  output logic              standby_o,
  output logic              strobe_o,
  output logic              err_o
);
  logic [CODE_W-1:0] code_q;
  logic              stby_q, strobe_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      stby_q   <= 1'b0;
      strobe_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      strobe_q <= load_i;
      if (load_i) begin
        code_q <= word_i.code;
        stby_q <= word_i.standby;
        if (|word_i.rsvd) err_q <= 1'b1;
      end
    end
  end

  assign code_o    = code_q;
  assign standby_o = stby_q;
  assign strobe_o  = strobe_q;
  assign err_o     = err_q;
endmodule

// File: rtl/tw_rx.sv
module tw_rx
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              sen_i,
  output logic [CODE_W-1:0] cap_code_o,
  output logic              standby_o,
  output logic              update_o,
  output logic              rsvd_err_o
);
  logic [LINES_N-1:0] raw, lvl, rise, fall;
  logic [WORD_W-1:0]  shift_word;
  logic               armed, sen_fall, load;

  always_comb begin
    raw = '0;
    raw[SCLK_IDX] = sclk_i;
    raw[SDAT_IDX] = sdat_i;
    raw[SEN_IDX]  = sen_i;
  end

  tw_sync #(.WIDTH(LINES_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(raw),
    .level_o(lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  tw_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rise[SEN_IDX]),
    .shift_i(rise[SCLK_IDX] & lvl[SEN_IDX]),
    .bit_i  (lvl[SDAT_IDX]),
    .word_o (shift_word),
    .armed_o(armed)
  );

  assign sen_fall = fall[SEN_IDX];
  assign load     = sen_fall & armed;

  tw_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .word_i   (tw_word_t'(shift_word)),
    .code_o   (cap_code_o),
    .standby_o(standby_o),
    .strobe_o (update_o),
    .err_o    (rsvd_err_o)
  );
endmodule

// File: rtl/tw_rx_chk.sv
module tw_rx_chk
  import tw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sen_fall,
  input logic [CODE_W-1:0] cap_code_o,
  input logic              standby_o,
  input logic              update_o,
  input logic              rsvd_err_o
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o); // R8
  AST_CODE_ONLY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_code_o != $past(cap_code_o)) |-> update_o); // R4
  AST_STBY_ONLY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o != $past(standby_o)) |-> update_o); // R5
  AST_LOAD_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(sen_fall)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_err_o |=> rsvd_err_o); // R6
  AST_ERR_WITH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsvd_err_o) |-> update_o); // R6
endmodule

bind tw_rx tw_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sen_fall  (sen_fall),
  .cap_code_o(cap_code_o),
  .standby_o (standby_o),
  .update_o  (update_o),
  .rsvd_err_o(rsvd_err_o)
);

// File: tb/tw_rx_tb_top.sv
module tw_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sen = 1'b0;
  logic [4:0] code;
  logic stby, upd, err;
  int checks = 0, errors = 0, strobes = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tw_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat), .sen_i(sen),
    .cap_code_o(code), .standby_o(stby), .update_o(upd), .rsvd_err_o(err)
  );

  always @(negedge clk) if (upd) strobes++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clock_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      wait_clk(2);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(2);
    end
  endtask

  // full frame; checks hold while enable high and the strobe count after fall
  task automatic frame(input logic [15:0] bits, input int n,
                       input logic [4:0] hold_code, input logic hold_stby);
    int s0;
    sen = 1'b1;
    wait_clk(4);
    clock_bits(bits, n);
    wait_clk(6);
    check("R4 code held while enable high", code, hold_code);
    check("R4 standby held while enable high", stby, hold_stby);
    s0 = strobes;
    sen = 1'b0;
    wait_clk(8);
    check("R8 one strobe per accepted word", strobes - s0, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  initial begin
    int s0;
    logic exp_err;
    do_reset();
    check("R1 reset code", code, 0);
    check("R1 reset standby", stby, 0);
    check("R1 reset strobe", upd, 0);
    check("R1 reset error", err, 0);

    // R3: 12 bits, last 8 are 0x05
    frame(16'h0F05, 12, 5'd0, 1'b0);
    check("R3 last eight bits kept", code, 5'h05);
    check("R3 standby", stby, 0);
    check("R3 no error", err, 0);

    // R7: enable pulse with no serial clock
    s0 = strobes;
    sen = 1'b1;
    wait_clk(6);
    sen = 1'b0;
    wait_clk(8);
    check("R7 code unchanged", code, 5'h05);
    check("R7 no strobe", strobes - s0, 0);

    // R9: load 0x03, clock junk with enable low, then 3-bit frame 110 -> 0x1E
    frame(16'h0003, 8, 5'h05, 1'b0);
    check("R9 setup word", code, 5'h03);
    clock_bits(16'h00FF, 8);
    wait_clk(6);
    check("R9 junk edges leave code", code, 5'h03);
    frame(16'h0006, 3, 5'h03, 1'b0);
    check("R9 short frame shifts only its bits", code, 5'h1E);
    check("R9 standby", stby, 0);

    // R2/R5/R6: exhaustive sweep of all words
    exp_err = 1'b0;
    for (int w = 0; w < 256; w++) begin
      logic [7:0] wv;
      logic [4:0] pc;
      logic       ps;
      wv = 8'(w);
      pc = code;
      ps = stby;
      frame({8'h00, wv}, 8, pc, ps);
      if (wv[7:6] != 2'b00) exp_err = 1'b1;
      check("R2 code from bits 4..0", code, wv[4:0]);
      check("R5 standby from bit 5", stby, wv[5]);
      check("R6 reserved error flag", err, exp_err);
    end

    // R6: word with clean reserved bits keeps flag set
    frame(16'h0011, 8, 5'h1F, 1'b1);
    check("R6 flag sticky", err, 1);
    check("R2 code after clean word", code, 5'h11);
    do_reset();
    check("R6 reset clears flag", err, 0);
    check("R1 code after second reset", code, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule